// File: doc/BRIEF.md
# Burst Memory Traffic Driver

This block is a bursting memory-mapped master meant to exercise the local port of a half-rate DDR-style memory controller. After the controller reports that its initialisation is complete, the driver writes a known pattern over a contiguous range of local addresses using multi-beat write bursts. It then reads the same range back with pipelined read bursts and compares every returned beat against the pattern it expects. The pattern is computed from the beat's local address, so no copy of the written data is stored.

The controller stalls the master with an active-high ready signal. While ready is low, the driver holds every command argument. A single-cycle burst-begin strobe marks the first cycle of each new command. Write beats may be spread out by stalls. Read beats are taken only when the controller flags them valid, and may arrive with gaps. The number of read bursts in flight is capped by a parameter.

The write-then-read pass is repeated a configurable number of times, after which a sticky done flag rises. Any mismatch sets a sticky fail flag and captures the local address of the first bad beat.

Top module: `bmt_driver`

## Requirements
- R1: After reset, and for as long as `init_done_i` has not been seen high, no command is presented: `write_o`, `read_o`, `burst_begin_o`, `done_o` and `fail_o` are all 0.
- R2: `burst_begin_o` is high in exactly the first cycle a command is presented. It is low in later cycles of a stalled command and during the second and later beats of a write burst.
- R3: While a command or write beat is presented and `ready_i` is low, `write_o`, `read_o`, `addr_o`, `size_o` and `wdata_o` keep their values. The start address also stays on `addr_o` for every beat of a write burst.
- R4: A write burst moves exactly BURST_LEN beats. Beat k carries pattern(start+k), where pattern(a) is the ADDR_W-bit address a replicated DATA_W/ADDR_W times. No other command is presented until the last beat has been accepted.
- R5: Each pass first issues NUM_BURSTS write bursts, then NUM_BURSTS read bursts. Both sets start at BASE_ADDR + i*BURST_LEN for i ascending, with `size_o` equal to BURST_LEN. `write_o` and `read_o` are never high together.
- R6: Read commands are issued back to back without waiting for data, but never more than MAX_OUTSTANDING read bursts are accepted and not yet fully returned.
- R7: Read data is consumed only on cycles with `rdata_valid_i` high, whatever `rdata_i` holds on other cycles. The n-th valid beat of a pass is checked against pattern(BASE_ADDR + n), regardless of gaps.
- R8: On the first mismatching beat, `fail_o` rises in the following cycle and `fail_addr_o` shows that beat's local address. Both then hold through later mismatches until reset.
- R9: A new pass starts only after all reads of the previous pass have returned. After NUM_PASSES passes, `done_o` rises once the last read beat has returned, stays high, and no further command is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| init_done_i | input | 1 | Controller initialisation complete |
| ready_i | input | 1 | Controller accepts the presented command or beat (high = accept) |
| rdata_i | input | DATA_W | Read data beat |
| rdata_valid_i | input | 1 | Read data beat valid |
| burst_begin_o | output | 1 | First cycle of a new command |
| write_o | output | 1 | Write command or write beat presented |
| read_o | output | 1 | Read command presented |
| addr_o | output | ADDR_W | Local start address of the burst |
| size_o | output | SIZE_W | Burst length in beats |
| wdata_o | output | DATA_W | Write data beat |
| done_o | output | 1 | All passes complete (sticky) |
| fail_o | output | 1 | A read beat mismatched (sticky) |
| fail_addr_o | output | ADDR_W | Local address of the first mismatching beat |

## Verification
Command-side outputs are registered-state functions with no combinational path from the inputs. The bench therefore drives `ready_i` and the read-return signals at the falling edge and, in the same half cycle, judges the handshake that the next rising edge will take. Burst-begin, hold, beat data and outstanding-count checks all belong to that one cycle.

`fail_o` and `fail_addr_o` are due one edge after the bad beat is consumed, so the bench checks them at the next falling edge. `done_o` is due two edges after the final read beat, and the bench checks that nothing is still owed to the design when it first sees the flag high.

// File: rtl/bmt_pkg.sv
package bmt_pkg;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_WRITE = 3'd1,
    PH_READ  = 3'd2,
    PH_DRAIN = 3'd3,
    PH_DONE  = 3'd4
  } phase_e;

endpackage

// File: rtl/bmt_sequencer.sv
module bmt_sequencer
  import bmt_pkg::*;
#(
  parameter int ADDR_W          = 16,
  parameter int DATA_W          = 256,
  parameter int BURST_LEN       = 2,
  parameter int NUM_BURSTS      = 4,
  parameter int MAX_OUTSTANDING = 2,
  parameter int NUM_PASSES      = 2,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 'h40,
  localparam int SIZE_W  = $clog2(BURST_LEN + 1),
  localparam int BEAT_W  = (BURST_LEN > 1) ? $clog2(BURST_LEN) : 1,
  localparam int BURST_W = (NUM_BURSTS > 1) ? $clog2(NUM_BURSTS) : 1,
  localparam int PASS_W  = (NUM_PASSES > 1) ? $clog2(NUM_PASSES) : 1,
  localparam int OUT_W   = $clog2(MAX_OUTSTANDING + 1),
  localparam int REPS    = DATA_W / ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              init_done_i,
  input  logic              ready_i,
  input  logic              retire_i,
  output logic              burst_begin_o,
  output logic              write_o,
  output logic              read_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [SIZE_W-1:0] size_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic              done_o
);

  phase_e             phase_q, phase_d;
  logic [BEAT_W-1:0]  beat_q, beat_d;
  logic [BURST_W-1:0] burst_q, burst_d;
  logic [PASS_W-1:0]  pass_q, pass_d;
  logic [OUT_W-1:0]   outst_q, outst_d;
  logic               first_q, first_d;

  logic beat_last, burst_last, pass_last, rd_room;
  logic [ADDR_W-1:0] beat_addr;

  assign beat_last  = (beat_q == BEAT_W'(BURST_LEN - 1));
  assign burst_last = (burst_q == BURST_W'(NUM_BURSTS - 1));
  assign pass_last  = (pass_q == PASS_W'(NUM_PASSES - 1));
  assign rd_room    = (outst_q < OUT_W'(MAX_OUTSTANDING));

  assign write_o       = (phase_q == PH_WRITE);
  assign read_o        = (phase_q == PH_READ) && rd_room;
  assign burst_begin_o = first_q && (write_o || read_o);
  assign done_o        = (phase_q == PH_DONE);

  assign addr_o    = BASE_ADDR + ADDR_W'(burst_q) * ADDR_W'(BURST_LEN);
  assign beat_addr = addr_o + ADDR_W'(beat_q);
  assign wdata_o   = {REPS{beat_addr}};
  assign size_o    = SIZE_W'(BURST_LEN);

  // outstanding read bursts: +1 on accepted read, -1 on last returned beat
  always_comb begin
    outst_d = outst_q;
    if (read_o && ready_i) outst_d = outst_d + OUT_W'(1);
    if (retire_i)          outst_d = outst_d - OUT_W'(1);
  end

  always_comb begin
    phase_d = phase_q;
    beat_d  = beat_q;
    burst_d = burst_q;
    pass_d  = pass_q;
    first_d = first_q;
    case (phase_q)
      PH_IDLE: begin
        if (init_done_i) begin
          phase_d = PH_WRITE;
          first_d = 1'b1;
        end
      end
      PH_WRITE: begin
        if (ready_i) begin
          if (beat_last) begin
            beat_d  = '0;
            first_d = 1'b1;
            if (burst_last) begin
              burst_d = '0;
              phase_d = PH_READ;
            end else begin
              burst_d = burst_q + BURST_W'(1);
            end
          end else begin
            beat_d  = beat_q + BEAT_W'(1);
            first_d = 1'b0;
          end
        end else begin
          first_d = 1'b0;
        end
      end
      PH_READ: begin
        if (rd_room) begin
          if (ready_i) begin
            first_d = 1'b1;
            if (burst_last) begin
              burst_d = '0;
              phase_d = PH_DRAIN;
            end else begin
              burst_d = burst_q + BURST_W'(1);
            end
          end else begin
            first_d = 1'b0;
          end
        end
      end
      PH_DRAIN: begin
        if (outst_q == '0) begin
          if (pass_last) begin
            phase_d = PH_DONE;
          end else begin
            pass_d  = pass_q + PASS_W'(1);
            phase_d = PH_WRITE;
            first_d = 1'b1;
          end
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      beat_q  <= '0;
      burst_q <= '0;
      pass_q  <= '0;
      outst_q <= '0;
      first_q <= 1'b0;
    end else begin
      phase_q <= phase_d;
      beat_q  <= beat_d;
      burst_q <= burst_d;
      pass_q  <= pass_d;
      outst_q <= outst_d;
      first_q <= first_d;
    end
  end

  a_r3_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    ((write_o || read_o) && !ready_i) |=>
      ((write_o || read_o) && $stable(write_o) && $stable(addr_o) && $stable(wdata_o)));

  a_r2_no_begin_after_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_begin_o && !ready_i) |=> !burst_begin_o);

  a_r4_beats_continue: assert property (@(posedge clk) disable iff (!rst_n)
    (write_o && ready_i && !beat_last) |=> (write_o && !burst_begin_o && !read_o));

  a_r5_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(write_o && read_o));

  a_r6_outstanding_cap: assert property (@(posedge clk) disable iff (!rst_n)
    outst_q <= OUT_W'(MAX_OUTSTANDING));

  a_r9_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> (done_o && !write_o && !read_o));

endmodule

// File: rtl/bmt_checker.sv
module bmt_checker #(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 256,
  parameter int BURST_LEN  = 2,
  parameter int NUM_BURSTS = 4,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 'h40,
  localparam int TOTAL  = BURST_LEN * NUM_BURSTS,
  localparam int IDX_W  = (TOTAL > 1) ? $clog2(TOTAL) : 1,
  localparam int BEAT_W = (BURST_LEN > 1) ? $clog2(BURST_LEN) : 1,
  localparam int REPS   = DATA_W / ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rvalid_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic              retire_o,
  output logic              fail_o,
  output logic [ADDR_W-1:0] fail_addr_o
);

  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [BEAT_W-1:0] rbeat_q, rbeat_d;
  logic              fail_q, fail_d;
  logic [ADDR_W-1:0] fail_addr_q, fail_addr_d;

  logic              idx_last, rbeat_last, mismatch;
  logic [ADDR_W-1:0] exp_addr;
  logic [DATA_W-1:0] exp_word;

  assign idx_last   = (idx_q == IDX_W'(TOTAL - 1));
  assign rbeat_last = (rbeat_q == BEAT_W'(BURST_LEN - 1));
  assign exp_addr   = BASE_ADDR + ADDR_W'(idx_q);
  assign exp_word   = {REPS{exp_addr}};
  assign mismatch   = rvalid_i && (rdata_i != exp_word);
  assign retire_o   = rvalid_i && rbeat_last;

  always_comb begin
    idx_d       = idx_q;
    rbeat_d     = rbeat_q;
    fail_d      = fail_q;
    fail_addr_d = fail_addr_q;
    if (rvalid_i) begin
      idx_d   = idx_last   ? '0 : idx_q + IDX_W'(1);
      rbeat_d = rbeat_last ? '0 : rbeat_q + BEAT_W'(1);
    end
    if (mismatch && !fail_q) begin
      fail_d      = 1'b1;
      fail_addr_d = exp_addr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q       <= '0;
      rbeat_q     <= '0;
      fail_q      <= 1'b0;
      fail_addr_q <= '0;
    end else begin
      idx_q       <= idx_d;
      rbeat_q     <= rbeat_d;
      fail_q      <= fail_d;
      fail_addr_q <= fail_addr_d;
    end
  end

  assign fail_o      = fail_q;
  assign fail_addr_o = fail_addr_q;

  a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    fail_q |=> (fail_q && $stable(fail_addr_q)));

  a_r8_first_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (mismatch && !fail_q) |=> (fail_q && fail_addr_q == $past(exp_addr)));

  a_r7_idle_no_move: assert property (@(posedge clk) disable iff (!rst_n)
    !rvalid_i |=> ($stable(idx_q) && $stable(rbeat_q)));

endmodule

// File: rtl/bmt_driver.sv
module bmt_driver #(
  parameter int ADDR_W          = 16,
  parameter int DATA_W          = 256,
  parameter int BURST_LEN       = 2,
  parameter int NUM_BURSTS      = 4,
  parameter int MAX_OUTSTANDING = 2,
  parameter int NUM_PASSES      = 2,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 'h40,
  localparam int SIZE_W = $clog2(BURST_LEN + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              init_done_i,
  input  logic              ready_i,
  input  logic [DATA_W-1:0] rdata_i,
  input  logic              rdata_valid_i,
  output logic              burst_begin_o,
  output logic              write_o,
  output logic              read_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [SIZE_W-1:0] size_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic              done_o,
  output logic              fail_o,
  output logic [ADDR_W-1:0] fail_addr_o
);

  logic retire;

  bmt_sequencer #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BURST_LEN(BURST_LEN),
    .NUM_BURSTS(NUM_BURSTS), .MAX_OUTSTANDING(MAX_OUTSTANDING),
    .NUM_PASSES(NUM_PASSES), .BASE_ADDR(BASE_ADDR)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .init_done_i(init_done_i), .ready_i(ready_i),
    .retire_i(retire), .burst_begin_o(burst_begin_o), .write_o(write_o),
    .read_o(read_o), .addr_o(addr_o), .size_o(size_o), .wdata_o(wdata_o),
    .done_o(done_o)
  );

  bmt_checker #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BURST_LEN(BURST_LEN),
    .NUM_BURSTS(NUM_BURSTS), .BASE_ADDR(BASE_ADDR)
  ) u_chk (
    .clk(clk), .rst_n(rst_n), .rvalid_i(rdata_valid_i), .rdata_i(rdata_i),
    .retire_o(retire), .fail_o(fail_o), .fail_addr_o(fail_addr_o)
  );

endmodule

// File: tb/bmt_driver_bench.sv
module bmt_driver_bench;

  localparam int AW   = 16;
  localparam int DW   = 256;
  localparam int BL   = 2;
  localparam int NB   = 4;
  localparam int MO   = 2;
  localparam int NP   = 2;
  localparam logic [AW-1:0] BASE = 16'h40;
  localparam int SW   = $clog2(BL + 1);
  localparam int SPAN = BL * NB;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          init_done_i;
  logic          ready_i;
  logic [DW-1:0] rdata_i;
  logic          rdata_valid_i;
  logic          burst_begin_o, write_o, read_o, done_o, fail_o;
  logic [AW-1:0] addr_o, fail_addr_o;
  logic [SW-1:0] size_o;
  logic [DW-1:0] wdata_o;

  always #4 clk = ~clk;

  bmt_driver u_bmt_driver (
    .clk(clk), .rst_n(rst_n), .init_done_i(init_done_i), .ready_i(ready_i),
    .rdata_i(rdata_i), .rdata_valid_i(rdata_valid_i),
    .burst_begin_o(burst_begin_o), .write_o(write_o), .read_o(read_o),
    .addr_o(addr_o), .size_o(size_o), .wdata_o(wdata_o), .done_o(done_o),
    .fail_o(fail_o), .fail_addr_o(fail_addr_o)
  );

  typedef struct { bit wr; logic [AW-1:0] addr; } cmd_t;

  cmd_t          exp_q[$];
  logic [AW-1:0] rd_q[$];
  logic [DW-1:0] mem [SPAN];

  int n_cmp = 0, n_bad = 0;
  int wr_rem, wr_k, b_out, max_out, beat_idx, inj_a, inj_b;
  int ready_mode, ret_div;
  logic [AW-1:0] wr_base, fail_exp_addr;
  bit prev_stall, fail_chk_pend, first_fail_done, early_cmd, done_seen, cmd_after_done;
  logic          s_wr, s_rd;
  logic [AW-1:0] s_addr;
  logic [SW-1:0] s_size;
  logic [DW-1:0] s_wdata;

  function automatic logic [DW-1:0] pat(logic [AW-1:0] a);
    return {(DW/AW){a}};
  endfunction

  task automatic check(bit ok, string msg);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s", msg);
    end
  endtask

  task automatic plan_run();
    cmd_t c;
    exp_q.delete();
    for (int p = 0; p < NP; p++) begin
      for (int b = 0; b < NB; b++) begin
        c.wr = 1'b1; c.addr = BASE + AW'(b * BL); exp_q.push_back(c);
      end
      for (int b = 0; b < NB; b++) begin
        c.wr = 1'b0; c.addr = BASE + AW'(b * BL); exp_q.push_back(c);
      end
    end
  endtask

  task automatic cycle();
    bit            valid, retire, exp_bb;
    logic [AW-1:0] a;
    logic [DW-1:0] d;
    cmd_t          c;
    @(negedge clk);
    if (fail_chk_pend) begin
      check(fail_o && fail_addr_o == fail_exp_addr,
        $sformatf("R8 first-mismatch capture: fail=%0b addr=%h expected fail=1 addr=%h",
                  fail_o, fail_addr_o, fail_exp_addr));
      fail_chk_pend = 0;
    end
    // drive inputs for the coming rising edge
    ready_i = (ready_mode == 0) ? 1'b1 : 1'($urandom % 2);
    retire = 0;
    if (rd_q.size() > 0 && ($urandom % ret_div) == 0) begin
      a = rd_q.pop_front();
      d = mem[int'(a - BASE)];
      if (beat_idx == inj_a || beat_idx == inj_b) begin
        d[0] = ~d[0];
        if (!first_fail_done) begin
          first_fail_done = 1;
          fail_chk_pend   = 1;
          fail_exp_addr   = a;
          check(!fail_o, $sformatf("R8 fail clear before first mismatch: fail=%0b expected 0", fail_o));
        end
      end
      rdata_valid_i = 1'b1;
      rdata_i       = d;
      beat_idx++;
      if (beat_idx % BL == 0) retire = 1;
    end else begin
      rdata_valid_i = 1'b0;
      rdata_i       = {8{$urandom}};   // garbage must be ignored (R7)
    end
    // judge the handshake the coming edge will take
    valid = write_o || read_o;
    if (!init_done_i && valid) early_cmd = 1;
    if (done_seen && valid) cmd_after_done = 1;
    if (done_o && !done_seen) begin
      done_seen = 1;
      check(rd_q.size() == 0 && b_out == 0 && exp_q.size() == 0,
        $sformatf("R9 done before work finished: beats owed=%0d out=%0d cmds left=%0d expected 0/0/0",
                  rd_q.size(), b_out, exp_q.size()));
    end
    if (write_o && read_o) check(0, "R5 write and read together: actual 1/1 expected exclusive");
    if (prev_stall)
      check(write_o == s_wr && read_o == s_rd && addr_o == s_addr && size_o == s_size &&
            (!s_wr || wdata_o == s_wdata),
        $sformatf("R3 hold under stall: wr=%0b rd=%0b addr=%h expected wr=%0b rd=%0b addr=%h",
                  write_o, read_o, addr_o, s_wr, s_rd, s_addr));
    if (valid || burst_begin_o) begin
      exp_bb = valid && !prev_stall && wr_rem == 0;
      check(burst_begin_o == exp_bb,
        $sformatf("R2 burst_begin=%0b expected %0b (addr=%h)", burst_begin_o, exp_bb, addr_o));
    end
    if (read_o && wr_rem != 0)
      check(0, $sformatf("R4 read during write burst: beats left=%0d expected 0", wr_rem));
    if (valid && ready_i) begin
      if (exp_q.size() == 0) begin
        check(0, $sformatf("R5 unexpected command wr=%0b addr=%h expected none", write_o, addr_o));
      end else if (write_o) begin
        if (wr_rem == 0) begin
          c = exp_q.pop_front();
          check(c.wr && addr_o == c.addr && size_o == SW'(BL),
            $sformatf("R5 command wr=1 addr=%h size=%0d expected wr=%0b addr=%h size=%0d",
                      addr_o, size_o, c.wr, c.addr, BL));
          wr_base = addr_o; wr_k = 0; wr_rem = BL;
        end else begin
          check(addr_o == wr_base,
            $sformatf("R3 address across beats: %h expected %h", addr_o, wr_base));
        end
        check(wdata_o == pat(wr_base + AW'(wr_k)),
          $sformatf("R4 beat %0d data %h expected %h", wr_k, wdata_o[AW-1:0], wr_base + AW'(wr_k)));
        mem[int'(wr_base - BASE) + wr_k] = wdata_o;
        wr_k++; wr_rem--;
      end else begin
        c = exp_q.pop_front();
        check(!c.wr && addr_o == c.addr && size_o == SW'(BL),
          $sformatf("R5 command rd addr=%h size=%0d expected wr=%0b addr=%h size=%0d",
                    addr_o, size_o, c.wr, c.addr, BL));
        check(b_out + 1 <= MO,
          $sformatf("R6 outstanding reads %0d expected <= %0d", b_out + 1, MO));
        b_out++;
        if (b_out > max_out) max_out = b_out;
        for (int k = 0; k < BL; k++) rd_q.push_back(addr_o + AW'(k));
      end
    end
    prev_stall = valid && !ready_i;
    s_wr = write_o; s_rd = read_o; s_addr = addr_o; s_size = size_o; s_wdata = wdata_o;
    if (retire) b_out--;
  endtask

  task automatic run(int mode, int div, int init_wait, int ia, int ib, bit expect_fail,
                     logic [AW-1:0] exp_faddr, bit need_full);
    int wd;
    rst_n = 1'b0; init_done_i = 1'b0; ready_i = 1'b0; rdata_valid_i = 1'b0; rdata_i = '0;
    ready_mode = mode; ret_div = div; inj_a = ia; inj_b = ib;
    wr_rem = 0; wr_k = 0; b_out = 0; max_out = 0; beat_idx = 0;
    prev_stall = 0; fail_chk_pend = 0; first_fail_done = 0;
    early_cmd = 0; done_seen = 0; cmd_after_done = 0;
    rd_q.delete();
    for (int i = 0; i < SPAN; i++) mem[i] = '0;
    plan_run();
    repeat (3) @(negedge clk);
    check(!write_o && !read_o && !burst_begin_o && !done_o && !fail_o,
      $sformatf("R1 reset state wr=%0b rd=%0b bb=%0b done=%0b fail=%0b expected all 0",
                write_o, read_o, burst_begin_o, done_o, fail_o));
    rst_n = 1'b1;
    repeat (init_wait) cycle();
    check(!early_cmd, "R1 command before init_done: actual seen expected none");
    init_done_i = 1'b1;
    wd = 0;
    while (!done_seen && wd < 4000) begin
      cycle();
      wd++;
    end
    if (!done_seen) check(0, "R9 watchdog: done_o never rose, expected high");
    repeat (10) cycle();
    check(done_o && !cmd_after_done,
      $sformatf("R9 done sticky and quiet: done=%0b cmd_after=%0b expected 1/0", done_o, cmd_after_done));
    check(exp_q.size() == 0,
      $sformatf("R5 commands not issued: %0d expected 0", exp_q.size()));
    check(fail_o == expect_fail && (!expect_fail || fail_addr_o == exp_faddr),
      $sformatf("R8/R7 end state fail=%0b addr=%h expected fail=%0b addr=%h",
                fail_o, fail_addr_o, expect_fail, exp_faddr));
    if (need_full)
      check(max_out == MO,
        $sformatf("R6 pipelined reads peak %0d expected %0d", max_out, MO));
  endtask

  initial begin
    // fast controller, no stalls, quick returns
    run(0, 1, 2, -1, -1, 1'b0, '0, 1'b0);
    // random stalls, sparse returns with gaps, delayed init
    run(1, 4, 15, -1, -1, 1'b0, '0, 1'b1);
    // corrupt beat 5 (addr BASE+5) and a later beat; first must be kept
    run(1, 2, 4, 5, 11, 1'b1, BASE + 16'd5, 1'b0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule